// File: doc/BRIEF.md
# Machine status word update unit

This unit holds the 32-bit primary control register of a processor core and applies the two decoded instructions that can write it. The first is a partial write. It takes a fixed 16-bit operand and touches only the four low mode flags: protection enable in bit 0, monitor coprocessor in bit 1, emulation in bit 2 and task switched in bit 3. The second is a full move that replaces all 32 bits.

The decoder presents a one-cycle strobe and a selector, with `instr_sel_i` = 0 for the partial write and 1 for the full move. Alongside these it supplies the source value, the current privilege level, a flag that is high in protected or virtual-8086 mode, and the LOCK-prefix flag. A write that is not blocked lands on the clock edge that samples the strobe. Any fault pulse or serialize pulse is registered on that same edge and lasts one cycle. Protection enable is driven out as its own signal so that neighbouring logic can follow the processor mode.

Top module: `msw_update_unit`

## Requirements
- R1: After reset the register reads 0 and `pe_o`, `gp_fault_o`, `ud_fault_o` and `serialize_o` are all 0.
- R2: When a partial write is accepted, register bits 3:0 take source bits 3:0, except that bit 0 keeps a 1 it already holds. Register bits 31:4 do not change.
- R3: A partial write never clears protection enable (bit 0). If bit 0 is 1, it stays 1 even when source bit 0 is 0.
- R4: A partial write ignores source bits 31:4, whatever their value.
- R5: When a full move is accepted, all 32 source bits are written. This can clear bit 0.
- R6: If the protected/virtual-8086 flag is 1 and the privilege level is not 0, either instruction raises `gp_fault_o` for one cycle and leaves the register unchanged.
- R7: An instruction carrying the LOCK flag raises `ud_fault_o` for one cycle and leaves the register unchanged. This holds in every mode.
- R8: When both the LOCK fault and the privilege fault apply, only `ud_fault_o` pulses. The two fault outputs are never high together.
- R9: When the protected/virtual-8086 flag is 0, the privilege level is ignored and the write goes ahead at any level.
- R10: `serialize_o` pulses for exactly one cycle after each accepted write and never with a fault.
- R11: `pe_o` always equals register bit 0.
- R12: While no strobe is present, the register does not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Decoded instruction strobe, one cycle |
| instr_sel_i | input | 1 | 0 = partial four-flag write, 1 = full register move |
| src_i | input | 32 | Source value; the partial write uses the low 16 bits |
| cpl_i | input | 2 | Current privilege level |
| prot_mode_i | input | 1 | High in protected or virtual-8086 mode |
| lock_i | input | 1 | LOCK prefix present |
| ctrl_reg_o | output | 32 | Control register contents |
| pe_o | output | 1 | Protection enable (register bit 0) |
| gp_fault_o | output | 1 | General-protection fault pulse, error code 0 |
| ud_fault_o | output | 1 | Invalid-opcode fault pulse |
| serialize_o | output | 1 | Serialize request pulse |

## Verification
The control register is visible at the ports at all times. A corrupted flag therefore shows on `ctrl_reg_o` and `pe_o` in the cycle right after the bad write, and the bench compares the whole word after every instruction. A wrong fault decision shows up in that same cycle in two ways: a fault pulse that is missing, extra, or the wrong kind, and a register that changed when it should have held (or held when it should have changed). A serialize pulse that lingers is caught one cycle later, when it should already have dropped.

// File: rtl/msw_pkg.sv
package msw_pkg;
  typedef enum logic {
    OP_FLAG_LOAD = 1'b0,
    OP_FULL_MOVE = 1'b1
  } msw_op_e;

  localparam int unsigned PE_BIT = 0;
endpackage

// File: rtl/msw_fault_check.sv
module msw_fault_check #(
  parameter int unsigned CPL_W = 2
) (
  input  logic             valid_i,
  input  logic             lock_i,
  input  logic             prot_mode_i,
  input  logic [CPL_W-1:0] cpl_i,
  output logic             ud_o,
  output logic             gp_o,
  output logic             accept_o
);
  logic priv_bad;

  assign priv_bad = prot_mode_i && (cpl_i != '0);
  // invalid opcode outranks the privilege fault
  assign ud_o     = valid_i && lock_i;
  assign gp_o     = valid_i && !lock_i && priv_bad;
  assign accept_o = valid_i && !lock_i && !priv_bad;
endmodule

// File: rtl/msw_next_value.sv
module msw_next_value
  import msw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 4
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] src_i,
  input  msw_op_e           op_i,
  output logic [DATA_W-1:0] next_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == PE_BIT) begin : g_pe
      // partial write may set protection enable but never clear it
      assign next_o[i] = (op_i == OP_FULL_MOVE) ? src_i[i] : (cur_i[i] | src_i[i]);
    end else if (i < FLAG_W) begin : g_flag
      assign next_o[i] = src_i[i];
    end else begin : g_keep
      assign next_o[i] = (op_i == OP_FULL_MOVE) ? src_i[i] : cur_i[i];
    end
  end
endmodule

// File: rtl/msw_update_unit.sv
module msw_update_unit
  import msw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MSW_W  = 16,
  parameter int unsigned FLAG_W = 4,
  parameter int unsigned CPL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic              instr_sel_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CPL_W-1:0]  cpl_i,
  input  logic              prot_mode_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] ctrl_reg_o,
  output logic              pe_o,
  output logic              gp_fault_o,
  output logic              ud_fault_o,
  output logic              serialize_o
);
  localparam int unsigned PAD_W = DATA_W - MSW_W;

  logic [DATA_W-1:0] ctrl_q, next_val, src_eff;
  logic              ud_d, gp_d, accept;
  msw_op_e           op;

  assign op = msw_op_e'(instr_sel_i);
  // partial write has a fixed 16-bit operand
  assign src_eff = (op == OP_FULL_MOVE) ? src_i : {{PAD_W{1'b0}}, src_i[MSW_W-1:0]};

  msw_fault_check #(.CPL_W(CPL_W)) u_fault (
    .valid_i    (instr_valid_i),
    .lock_i     (lock_i),
    .prot_mode_i(prot_mode_i),
    .cpl_i      (cpl_i),
    .ud_o       (ud_d),
    .gp_o       (gp_d),
    .accept_o   (accept)
  );

  msw_next_value #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_next (
    .cur_i (ctrl_q),
    .src_i (src_eff),
    .op_i  (op),
    .next_o(next_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      gp_fault_o  <= 1'b0;
      ud_fault_o  <= 1'b0;
      serialize_o <= 1'b0;
    end else begin
      if (accept) ctrl_q <= next_val;
      gp_fault_o  <= gp_d;
      ud_fault_o  <= ud_d;
      serialize_o <= accept;
    end
  end

  assign ctrl_reg_o = ctrl_q;
  assign pe_o       = ctrl_q[PE_BIT];
endmodule

// File: rtl/msw_update_unit_chk.sv
module msw_update_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_valid_i,
  input logic              instr_sel_i,
  input logic              lock_i,
  input logic [DATA_W-1:0] ctrl_reg_o,
  input logic              pe_o,
  input logic              gp_fault_o,
  input logic              ud_fault_o,
  input logic              serialize_o
);
  assert_upper_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !instr_sel_i) |=> (ctrl_reg_o[DATA_W-1:FLAG_W] == $past(ctrl_reg_o[DATA_W-1:FLAG_W])));

  assert_pe_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !instr_sel_i && pe_o) |=> pe_o);

  assert_lock_ud_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && lock_i) |=> (ud_fault_o && $stable(ctrl_reg_o)));

  assert_one_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gp_fault_o && ud_fault_o));

  assert_ser_no_fault_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serialize_o |-> !(gp_fault_o || ud_fault_o));

  assert_pe_mirror_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_o == ctrl_reg_o[0]);

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> ($stable(ctrl_reg_o) && !serialize_o));
endmodule

bind msw_update_unit msw_update_unit_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_valid_i(instr_valid_i),
  .instr_sel_i  (instr_sel_i),
  .lock_i       (lock_i),
  .ctrl_reg_o   (ctrl_reg_o),
  .pe_o         (pe_o),
  .gp_fault_o   (gp_fault_o),
  .ud_fault_o   (ud_fault_o),
  .serialize_o  (serialize_o)
);

// File: tb/msw_update_unit_tb.sv
module msw_update_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic        instr_sel_i = 1'b0;
  logic [31:0] src_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        prot_mode_i = 1'b0;
  logic        lock_i = 1'b0;
  logic [31:0] ctrl_reg_o;
  logic        pe_o, gp_fault_o, ud_fault_o, serialize_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  msw_update_unit dut_i (
    .clk_i, .rst_ni, .instr_valid_i, .instr_sel_i, .src_i, .cpl_i,
    .prot_mode_i, .lock_i, .ctrl_reg_o, .pe_o, .gp_fault_o, .ud_fault_o, .serialize_o
  );

  typedef struct packed {
    logic        sel;
    logic [31:0] src;
    logic [1:0]  cpl;
    logic        prot;
    logic        lock;
    logic [31:0] exp_reg;
    logic        exp_gp;
    logic        exp_ud;
    logic        exp_ser;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_000E, 2'd0, 1'b0, 1'b0, 32'h0000_000E, 1'b0, 1'b0, 1'b1}, // R2
    '{1'b0, 32'hFFFF_FFF1, 2'd0, 1'b0, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 1'b1}, // R4 R2
    '{1'b0, 32'h0000_0000, 2'd0, 1'b0, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 1'b1}, // R3
    '{1'b1, 32'h8000_0011, 2'd0, 1'b1, 1'b0, 32'h8000_0011, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b0, 32'h0000_0006, 2'd3, 1'b1, 1'b0, 32'h8000_0011, 1'b1, 1'b0, 1'b0}, // R6
    '{1'b0, 32'h0000_0006, 2'd0, 1'b1, 1'b1, 32'h8000_0011, 1'b0, 1'b1, 1'b0}, // R7
    '{1'b0, 32'h0000_0006, 2'd2, 1'b1, 1'b1, 32'h8000_0011, 1'b0, 1'b1, 1'b0}, // R8
    '{1'b0, 32'h0000_0006, 2'd3, 1'b0, 1'b0, 32'h8000_0017, 1'b0, 1'b0, 1'b1}, // R9 R3
    '{1'b1, 32'h0000_0000, 2'd1, 1'b1, 1'b0, 32'h8000_0017, 1'b1, 1'b0, 1'b0}, // R6
    '{1'b1, 32'h0000_0000, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b1, 32'h1234_5678, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 1'b0}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk_i);
    instr_valid_i = 1'b1;
    instr_sel_i   = v.sel;
    src_i         = v.src;
    cpl_i         = v.cpl;
    prot_mode_i   = v.prot;
    lock_i        = v.lock;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    lock_i        = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reg", ctrl_reg_o, 32'h0);
    chk("R1 pulses", {28'h0, pe_o, gp_fault_o, ud_fault_o, serialize_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      chk($sformatf("vec%0d reg", i), ctrl_reg_o, VECS[i].exp_reg);
      chk($sformatf("vec%0d gp", i), {31'h0, gp_fault_o}, {31'h0, VECS[i].exp_gp});
      chk($sformatf("vec%0d ud", i), {31'h0, ud_fault_o}, {31'h0, VECS[i].exp_ud});
      chk($sformatf("vec%0d R10 ser", i), {31'h0, serialize_o}, {31'h0, VECS[i].exp_ser});
      chk($sformatf("vec%0d R11 pe", i), {31'h0, pe_o}, {31'h0, VECS[i].exp_reg[0]});
      @(negedge clk_i);
      chk($sformatf("vec%0d R10 pulse end", i),
          {29'h0, gp_fault_o, ud_fault_o, serialize_o}, 32'h0);
    end

    // R12: inputs move with no strobe
    issue('{1'b1, 32'hA5A5_0003, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1});
    chk("R5 setup", ctrl_reg_o, 32'hA5A5_0003);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      src_i = 32'h0F0F_0000 + k; instr_sel_i = k[0]; lock_i = k[1];
      @(negedge clk_i);
      chk("R12 hold", ctrl_reg_o, 32'hA5A5_0003);
    end
    lock_i = 1'b0;

    // R3: repeated partial clears of PE, upper bits kept (R2)
    issue('{1'b0, 32'h0000_0008, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1});
    chk("R3 pe sticky", ctrl_reg_o, 32'hA5A5_0009);
    chk("R11 pe out", {31'h0, pe_o}, 32'h1);

    // R1: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1 chk("R1 async reset", ctrl_reg_o, 32'h0);
    chk("R1 pe after reset", {31'h0, pe_o}, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule